// File: doc/BRIEF.md
# Multi-Source System Reset Sequencer

This block merges four reset requests into one internal system reset and runs the sequence from reset entry to the first instruction fetch. The four requests are an active-low reset pin, a watchdog overflow pulse, a power-on supply-good flag and a low-voltage supply-good flag. Every source has the same effect inside the chip. The reset is applied without waiting for a clock edge and is removed in step with the clock. While the reset is applied, the oscillator enables are off and the external clock inputs are not accepted. After every source has gone quiet, a counter waits out the oscillator settling time. Only then is the CPU allowed to run. For that whole span the port pads are held in their safe state.

The pin request passes through a two-stage synchronizer and a minimum-width filter. The filter counts cycles of the always-running reference clock that times the whole block, so short glitches on the pin are rejected. A sticky cause register records which sources produced the most recent reset, and software clears it by writing ones. A single cycle of `boot_fetch` tells the CPU to read its two-byte start vector from addresses 0x0000 and 0x0001. The CPU does this on the internal high-speed clock.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n`, `cpu_run`, `boot_fetch`, `osc_en` and `ext_clk_en` are 0, `pad_safe` is 1 and `cause` is 0000.
- R2: A high `wdt_ovf`, a low `poc_ok` or a low `lvi_ok` drives `sys_rst_n` low at once, with no clock edge needed.
- R3: A low level on `pin_rst_n` that covers at most FILT_CYC rising clock edges has no effect: no reset and `cause` unchanged. A low level that covers FILT_CYC+1 edges or more causes a reset.
- R4: `sys_rst_n` stays low while any source is active. It returns high on the 2nd rising edge after the last source goes inactive. For the pin this is the 4th edge after the pin goes high, because of the two synchronizer stages.
- R5: `cpu_run` rises STAB_CYC rising edges after `sys_rst_n` returns high. A watchdog reset releases by itself after a single-cycle pulse.
- R6: `pad_safe` (every port output off, the one designated pin driven low) is 1 from reset entry until `cpu_run` rises, and 0 after that.
- R7: `osc_en` is 0 while `sys_rst_n` is 0. `ext_clk_en` is 0 until `cpu_run` rises.
- R8: `boot_fetch` is high for exactly the first cycle in which `cpu_run` is high.
- R9: `cause` bit 0 is the pin, bit 1 the watchdog, bit 2 power-on and bit 3 low-voltage. A source's bit is set on every clock edge at which that source is active. Watchdog and low-voltage resets add their bit to the bits already set.
- R10: At the onset of a pin reset or a power-on reset, all other `cause` bits are cleared before the new bits are set.
- R11: A clock edge with `cause_clr_we` high clears the `cause` bits that are set in `cause_clr_mask`. With `cause_clr_we` low the mask has no effect. A source that is active on the same edge keeps its bit set.
- R12: A source that becomes active during the settling wait restarts the whole sequence from reset entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| arst_n | input | 1 | Block power-up reset, active low |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow request, high while active |
| poc_ok | input | 1 | Supply at or above the power-on threshold |
| lvi_ok | input | 1 | Supply at or above the low-voltage threshold |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 4 | Cause bits to clear (1 clears) |
| sys_rst_n | output | 1 | Internal system reset, active low |
| pad_safe | output | 1 | Pads held in reset state |
| osc_en | output | 1 | Oscillator enable |
| ext_clk_en | output | 1 | External clock inputs accepted |
| cpu_run | output | 1 | CPU may execute |
| boot_fetch | output | 1 | One-cycle start-vector fetch request |
| cause | output | 4 | Sticky reset-cause flags |

## Verification
The hardest situations to reach from the ports are pin pulses right at the filter threshold and a new request that arrives in the middle of the settling wait. The bench sweeps the pin low width from one edge up to three edges past the threshold. For each width it predicts whether a reset occurs and on which edge the run resumes. It also fires a watchdog pulse partway through a settling wait and expects the full count to restart. Overlapping supply flags are released one at a time, which shows that the reset is held until the last source is quiet.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int SRC_N   = 4;
  localparam int SRC_PIN = 0;
  localparam int SRC_WDT = 1;
  localparam int SRC_POC = 2;
  localparam int SRC_LVI = 3;
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic pin_act
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYC);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          cnt_en;

  // count only while the synchronized pin is low, saturate at the limit
  assign cnt_en = ~sync2_q && (low_cnt_q != CNT_TOP);

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (sync2_q)     low_cnt_d = '0;
    else if (cnt_en) low_cnt_d = low_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1_q   <= 1'b1;
      sync2_q   <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      sync1_q   <= pin_n;
      sync2_q   <= sync1_q;
      low_cnt_q <= low_cnt_d;
    end
  end

  assign pin_act = ~sync2_q && (low_cnt_q == CNT_TOP);

  // R3
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pin_act) |-> $past(!sync2_q));
endmodule

// File: rtl/rstseq_rst_sync.sv
module rstseq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic src_any,
  output logic sys_rst_n
);
  logic clr_n;
  logic stage1_q, stage2_q;

  assign clr_n = arst_n & ~src_any;

  // immediate entry, clocked exit
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign sys_rst_n = stage2_q;

  // R4
  release_needs_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(stage2_q) |-> $past(clr_n));
endmodule

// File: rtl/rstseq_stab_seq.sv
module rstseq_stab_seq #(
  parameter int STAB_CYC = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sys_rst_n,
  output logic run,
  output logic boot_fetch
);
  localparam int CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(STAB_CYC);

  logic [CW-1:0] wait_cnt_q, wait_cnt_d;
  logic          wait_en;
  logic          run_q;

  assign wait_en = (wait_cnt_q != CNT_TOP);

  always_comb begin
    wait_cnt_d = wait_cnt_q;
    if (wait_en) wait_cnt_d = wait_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      wait_cnt_q <= '0;
      run_q      <= 1'b0;
    end else begin
      wait_cnt_q <= wait_cnt_d;
      run_q      <= run;
    end
  end

  assign run        = (wait_cnt_q == CNT_TOP);
  assign boot_fetch = run & ~run_q;

  // R8
  fetch_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
    boot_fetch |=> !boot_fetch);
  // R5
  run_needs_rel_chk: assert property (@(posedge clk) disable iff (!arst_n)
    run |-> $past(sys_rst_n));
endmodule

// File: rtl/rstseq_cause_reg.sv
module rstseq_cause_reg
  import rstseq_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  src_vec_t src_act,
  input  logic     clr_we,
  input  src_vec_t clr_mask,
  output src_vec_t cause
);
  src_vec_t src_q, onset, cause_q, cause_d;

  assign onset = src_act & ~src_q;

  always_comb begin
    cause_d = cause_q;
    if (onset[SRC_PIN] || onset[SRC_POC]) cause_d = '0;
    if (clr_we) cause_d = cause_d & ~clr_mask;
    cause_d = cause_d | src_act;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      src_q   <= '0;
      cause_q <= '0;
    end else begin
      src_q   <= src_act;
      cause_q <= cause_d;
    end
  end

  assign cause = cause_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_chk
    // R9
    cause_set_chk: assert property (@(posedge clk) disable iff (!arst_n)
      src_act[g] |=> cause_q[g]);
    // R11
    cause_from_src_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(cause_q[g]) |-> $past(src_act[g]));
  end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int FILT_CYC = 3,
  parameter int STAB_CYC = 16
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pin_rst_n,
  input  logic       wdt_ovf,
  input  logic       poc_ok,
  input  logic       lvi_ok,
  input  logic       cause_clr_we,
  input  logic [3:0] cause_clr_mask,
  output logic       sys_rst_n,
  output logic       pad_safe,
  output logic       osc_en,
  output logic       ext_clk_en,
  output logic       cpu_run,
  output logic       boot_fetch,
  output logic [3:0] cause
);
  logic     pin_act;
  src_vec_t src_act;

  rstseq_pin_filter #(.FILT_CYC(FILT_CYC)) u_pin (
    .clk(clk), .arst_n(arst_n), .pin_n(pin_rst_n), .pin_act(pin_act));

  always_comb begin
    src_act          = '0;
    src_act[SRC_PIN] = pin_act;
    src_act[SRC_WDT] = wdt_ovf;
    src_act[SRC_POC] = ~poc_ok;
    src_act[SRC_LVI] = ~lvi_ok;
  end

  rstseq_rst_sync u_sync (
    .clk(clk), .arst_n(arst_n), .src_any(|src_act), .sys_rst_n(sys_rst_n));

  rstseq_stab_seq #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk(clk), .arst_n(arst_n), .sys_rst_n(sys_rst_n),
    .run(cpu_run), .boot_fetch(boot_fetch));

  rstseq_cause_reg u_cause (
    .clk(clk), .arst_n(arst_n), .src_act(src_act),
    .clr_we(cause_clr_we), .clr_mask(cause_clr_mask), .cause(cause));

  assign pad_safe   = ~cpu_run;
  assign osc_en     = sys_rst_n;
  assign ext_clk_en = cpu_run;

  // R7
  ext_clk_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !sys_rst_n |-> !ext_clk_en);
endmodule

// File: tb/rstseq_ctrl_tb_top.sv
module rstseq_ctrl_tb_top;
  localparam int FILT = 4;
  localparam int STAB = 6;

  logic clk = 1'b0;
  logic arst_n, pin_rst_n, wdt_ovf, poc_ok, lvi_ok, cause_clr_we;
  logic [3:0] cause_clr_mask;
  logic sys_rst_n, pad_safe, osc_en, ext_clk_en, cpu_run, boot_fetch;
  logic [3:0] cause;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rstseq_ctrl #(.FILT_CYC(FILT), .STAB_CYC(STAB)) dut_i (
    .clk(clk), .arst_n(arst_n), .pin_rst_n(pin_rst_n), .wdt_ovf(wdt_ovf),
    .poc_ok(poc_ok), .lvi_ok(lvi_ok), .cause_clr_we(cause_clr_we),
    .cause_clr_mask(cause_clr_mask), .sys_rst_n(sys_rst_n), .pad_safe(pad_safe),
    .osc_en(osc_en), .ext_clk_en(ext_clk_en), .cpu_run(cpu_run),
    .boot_fetch(boot_fetch), .cause(cause));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // counts edges from the current point until the CPU runs again
  task automatic wait_run(input int exp_rel, input string tag);
    int n = 0;
    int rel = -1;
    int ok = 1;
    do begin
      step();
      n++;
      if (sys_rst_n && rel < 0) rel = n;
      if (!sys_rst_n) rel = -1;
      if (!cpu_run && !pad_safe) ok = 0;
      if (!sys_rst_n && osc_en) ok = 0;
      if (!cpu_run && ext_clk_en) ok = 0;
    end while (!cpu_run && n < 200);
    chk({tag, " R4 release edge"}, rel, exp_rel);
    chk({tag, " R5 run edge"}, n, exp_rel + STAB);
    chk({tag, " R6 R7 pads and clocks held"}, ok, 1);
    chk({tag, " R8 fetch pulse"}, int'(boot_fetch), 1);
    chk({tag, " R6 pads released"}, int'(pad_safe), 0);
    chk({tag, " R7 ext clock on"}, int'(ext_clk_en), 1);
    step();
    chk({tag, " R8 fetch single"}, int'(boot_fetch), 0);
  endtask

  task automatic wdt_pulse(input string tag);
    wdt_ovf = 1'b1;
    #1;
    chk({tag, " R2 immediate assert"}, int'(sys_rst_n), 0);
    step();
    wdt_ovf = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; pin_rst_n = 1'b1; wdt_ovf = 1'b0; poc_ok = 1'b1; lvi_ok = 1'b1;
    cause_clr_we = 1'b0; cause_clr_mask = 4'h0;
    step(); step();
    // R1
    chk("R1 sys_rst_n", int'(sys_rst_n), 0);
    chk("R1 cpu_run", int'(cpu_run), 0);
    chk("R1 pad_safe", int'(pad_safe), 1);
    chk("R1 osc_en", int'(osc_en), 0);
    chk("R1 ext_clk_en", int'(ext_clk_en), 0);
    chk("R1 boot_fetch", int'(boot_fetch), 0);
    chk("R1 cause", int'(cause), 0);
    arst_n = 1'b1;
    wait_run(2, "power-up");

    // R9 watchdog sets bit 1
    wdt_pulse("wdt");
    wait_run(2, "wdt R5 self release");
    chk("R9 wdt cause", int'(cause), 4'b0010);

    // R3 sweep of pin low widths
    for (int w = 1; w <= FILT + 3; w++) begin
      int low_seen = 0;
      pin_rst_n = 1'b0;
      for (int i = 0; i < w; i++) begin
        step();
        if (!sys_rst_n) low_seen = 1;
      end
      pin_rst_n = 1'b1;
      if (w <= FILT) begin
        for (int i = 0; i < 12; i++) begin
          step();
          if (!sys_rst_n || !cpu_run) low_seen = 1;
        end
        chk($sformatf("R3 width %0d ignored", w), low_seen, 0);
        chk($sformatf("R3 width %0d cause kept", w), int'(cause), 4'b0010);
      end else begin
        wait_run(4, $sformatf("R3 width %0d", w));
        chk($sformatf("R10 pin width %0d cause", w), int'(cause), 4'b0001);
      end
    end

    wdt_pulse("wdt2");
    wait_run(2, "wdt2");
    chk("R9 wdt accumulates", int'(cause), 4'b0011);

    // low-voltage held, with a clear attempt during the hold
    begin
      int held = 1;
      lvi_ok = 1'b0;
      #1;
      chk("R2 lvi immediate", int'(sys_rst_n), 0);
      step();
      cause_clr_we = 1'b1; cause_clr_mask = 4'b1000;
      step();
      cause_clr_we = 1'b0;
      chk("R11 set beats clear", int'(cause), 4'b1011);
      for (int i = 0; i < 5; i++) begin
        step();
        if (sys_rst_n) held = 0;
      end
      chk("R4 held while lvi low", held, 1);
      lvi_ok = 1'b1;
      wait_run(2, "lvi");
    end

    cause_clr_we = 1'b0; cause_clr_mask = 4'b1111;
    step();
    chk("R11 mask without strobe", int'(cause), 4'b1011);
    cause_clr_we = 1'b1; cause_clr_mask = 4'b0011;
    step();
    cause_clr_we = 1'b0;
    chk("R11 write-one clear", int'(cause), 4'b1000);

    // power-on reset clears older flags
    poc_ok = 1'b0;
    #1;
    chk("R2 poc immediate", int'(sys_rst_n), 0);
    step(); step();
    chk("R10 poc clears first", int'(cause), 4'b0100);
    poc_ok = 1'b1;
    wait_run(2, "poc");

    // overlapping supply flags, released one by one
    begin
      int held = 1;
      poc_ok = 1'b0; lvi_ok = 1'b0;
      step(); step(); step();
      poc_ok = 1'b1;
      for (int i = 0; i < 5; i++) begin
        step();
        if (sys_rst_n) held = 0;
      end
      chk("R4 held by remaining source", held, 1);
      chk("R10 overlap cause", int'(cause), 4'b1100);
      lvi_ok = 1'b1;
      wait_run(2, "overlap");
    end

    // R12 watchdog inside the settling wait
    lvi_ok = 1'b0;
    step(); step();
    lvi_ok = 1'b1;
    step(); step(); step();
    chk("R12 still waiting", int'(cpu_run), 0);
    wdt_pulse("R12 restart");
    wait_run(2, "R12 restart");
    chk("R9 R12 cause", int'(cause), 4'b1110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule